// File: doc/BRIEF.md
# Prefetch Request Queue Controller

This block holds a bounded list of pending hardware prefetch addresses between a prefetch address generator and the memory-side request port of a cache. Demand-miss notifications arrive with a time stamp. Each accepted notification removes any queued entry for the same block. It can also trim entries that are not yet due from the tail of the list. The generator then offers candidate block addresses one per cycle, each with its own delay. A candidate's ready time is the time stamp of the latest accepted notification plus that delay. A candidate whose block is already queued is dropped.

When the cache port wants a prefetch it pulses an issue request. The block then walks the list from the oldest entry, one entry per cycle. It presents the head address on a lookup port and reads back two combinational answers: present in the cache, and present in the miss-status registers. Any entry found in either is thrown away and the walk moves on. The first entry found in neither is handed out. A request-pending output stays high while the list is non-empty. Eight event counters record what happened to each candidate and entry.

Top module: `prefetch_queue_ctrl`

## Requirements
- R1: Every address is reduced to its block address by clearing the low log2(BLK_BYTES) bits (6 bits by default). All matching uses block addresses, and issue_addr is always block aligned.
- R2: A notification is ignored when ntf_uncached is high, or when ntf_ifetch and cfg_data_only are both high. An ignored notification leaves the queue, the time base and the counters unchanged.
- R3: An accepted notification whose block address matches a queued entry removes that entry and adds one to the miss-removal counter. The other entries keep their order.
- R4: With cfg_serial_squash high, an accepted notification at time T removes entries from the tail toward the head while their ready time is greater than or equal to T. It stops at the first entry with an earlier ready time. Each removed entry adds one to the squash counter. With cfg_serial_squash low, nothing is squashed.
- R5: An accepted candidate that is not already queued is appended at the tail with ready time = (time of the last accepted notification) + cand_delay. head_time shows the ready time of the oldest entry, or 0 when the queue is empty.
- R6: Every candidate taken adds one to the identified counter. A candidate whose block address is already queued is dropped and adds one to the buffer-hit counter.
- R7: A new, non-duplicate candidate that arrives while DEPTH entries are queued first discards the oldest entry and adds one to the full-removal counter. The queue never holds more than DEPTH entries.
- R8: An issue_req pulse, given while no walk is in progress, starts a walk in the next cycle. Each walk cycle examines the head. A cache hit discards the head and counts a cache hit; the cache is checked first. Otherwise a miss-status hit discards it and counts a miss-status hit. Otherwise the head is popped and reported with issue_done=1, issue_found=1 and issue_addr, and the issued counter is incremented. If the queue is empty, the walk ends with issue_done=1 and issue_found=0. issue_done is visible 2 cycles after issue_req, plus 1 cycle for each skipped entry.
- R9: mem_req is high exactly when the queue holds at least one entry. It falls as soon as removal, squash or issue filtering empties the queue.
- R10: In each cycle ntf_valid takes precedence over cand_valid, and cand_valid takes precedence over a walk step. A candidate presented together with ntf_valid is discarded. A walk step waits while either input is valid.
- R11: After reset the queue is empty, mem_req, issue_done and head_time are 0, and every counter is 0.
- R12: ev_counts holds eight CW-bit counters (16 by default) that wrap. Field k sits at bits [k*CW +: CW] in this order: k=0 identified, 1 buffer hit, 2 cache hit, 3 miss-status hit, 4 full removal, 5 miss removal, 6 squashed, 7 issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch notifications |
| cfg_serial_squash | input | 1 | Enable tail squash on notification |
| ntf_valid | input | 1 | Miss notification strobe |
| ntf_addr | input | AW | Miss byte address |
| ntf_time | input | TW | Miss time stamp |
| ntf_uncached | input | 1 | Miss is to uncacheable memory |
| ntf_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate strobe |
| cand_addr | input | AW | Candidate byte address |
| cand_delay | input | DW | Candidate delay added to the time base |
| issue_req | input | 1 | Request for one prefetch |
| probe_addr | output | AW | Head block address for the lookups |
| probe_cache_hit | input | 1 | probe_addr is present in the cache |
| probe_mshr_hit | input | 1 | probe_addr is present in the miss-status registers |
| issue_done | output | 1 | One-cycle pulse: walk finished |
| issue_found | output | 1 | With issue_done: an address was handed out |
| issue_addr | output | AW | Issued block address |
| mem_req | output | 1 | Prefetch request pending toward memory |
| head_time | output | TW | Ready time of the oldest entry, 0 if empty |
| ev_counts | output | 8*CW | Packed event counters |

## Verification
Most internal state shows at the ports within one cycle. A wrong entry count or a lost entry shows up in mem_req and head_time right after the operation. A bad compaction after a middle removal or a squash shows up as the wrong issued address, or the wrong issue order, once the queue is drained. An off-by-one in the squash cut, or in the full-queue eviction, shows up in head_time and in the order of the drained addresses. A fault in the walk shows up as an issue_done latency other than two cycles plus one per skipped entry, or as a counter attributing a skip to the wrong lookup.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int NUM_EV      = 8;
  localparam int EV_IDENT    = 0;
  localparam int EV_BUFHIT   = 1;
  localparam int EV_CACHEHIT = 2;
  localparam int EV_MSHRHIT  = 3;
  localparam int EV_FULLDROP = 4;
  localparam int EV_MISSDROP = 5;
  localparam int EV_SQUASH   = 6;
  localparam int EV_ISSUE    = 7;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_NOTE = 2'd1,
    OP_CAND = 2'd2,
    OP_STEP = 2'd3
  } op_e;
endpackage

// File: rtl/pfq_match.sv
// Parallel block-address compare against the occupied slots.
module pfq_match #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0]   key,
  input  logic [AW-1:0]   ent [DEPTH],
  input  logic [CNTW-1:0] used,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  logic [DEPTH-1:0] eq;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = (CNTW'(g) < used) && (ent[g] == key);
    end
  endgenerate

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/pfq_cutoff.sv
// Number of entries kept by a tail squash: one past the highest slot that
// is due strictly before the threshold.
module pfq_cutoff #(
  parameter int TW    = 16,
  parameter int DEPTH = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic [TW-1:0]   rdy [DEPTH],
  input  logic [CNTW-1:0] used,
  input  logic [TW-1:0]   thresh,
  output logic [CNTW-1:0] keep
);
  always_comb begin
    keep = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNTW'(i) < used) && (rdy[i] < thresh)) keep = CNTW'(i + 1);
    end
  end
endmodule

// File: rtl/pfq_evcnt.sv
// Bank of wrapping event counters with multi-count increments.
module pfq_evcnt #(
  parameter int NEV = 8,
  parameter int CW  = 16,
  parameter int IW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     inc [NEV],
  output logic [NEV*CW-1:0] cnt_flat
);
  generate
    for (genvar g = 0; g < NEV; g++) begin : g_ctr
      logic [CW-1:0] c;
      always_ff @(posedge clk) begin
        if (rst) c <= '0;
        else     c <= c + CW'(inc[g]);
      end
      assign cnt_flat[g*CW +: CW] = c;
    end
  endgenerate
endmodule

// File: rtl/prefetch_queue_ctrl.sv
module prefetch_queue_ctrl
  import pfq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 8,
  parameter int TW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_data_only,
  input  logic                 cfg_serial_squash,
  input  logic                 ntf_valid,
  input  logic [AW-1:0]        ntf_addr,
  input  logic [TW-1:0]        ntf_time,
  input  logic                 ntf_uncached,
  input  logic                 ntf_ifetch,
  input  logic                 cand_valid,
  input  logic [AW-1:0]        cand_addr,
  input  logic [DW-1:0]        cand_delay,
  input  logic                 issue_req,
  output logic [AW-1:0]        probe_addr,
  input  logic                 probe_cache_hit,
  input  logic                 probe_mshr_hit,
  output logic                 issue_done,
  output logic                 issue_found,
  output logic [AW-1:0]        issue_addr,
  output logic                 mem_req,
  output logic [TW-1:0]        head_time,
  output logic [NUM_EV*CW-1:0] ev_counts
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  // queue storage: slot 0 is the oldest entry
  logic [AW-1:0]   q_addr [DEPTH];
  logic [TW-1:0]   q_rdy  [DEPTH];
  logic [AW-1:0]   n_addr [DEPTH];
  logic [TW-1:0]   n_rdy  [DEPTH];
  logic [AW-1:0]   a_addr [DEPTH];
  logic [TW-1:0]   a_rdy  [DEPTH];
  logic [AW-1:0]   s_addr [DEPTH];
  logic [TW-1:0]   s_rdy  [DEPTH];
  logic [CNTW-1:0] count, n_count, cnt1, keep;
  logic [TW-1:0]   base_time, n_base;
  logic            searching, n_search;
  logic            n_done, n_found;
  logic [AW-1:0]   n_iaddr;
  logic [CNTW-1:0] ev_inc [NUM_EV];

  logic            ntf_take;
  op_e             op;
  logic [AW-1:0]   ntf_blk, cand_blk;
  logic [TW-1:0]   cand_rdy;
  logic            n_hit, c_hit;
  logic [IDXW-1:0] n_idx, c_idx;

  assign ntf_blk  = ntf_addr & ~OFF_MASK;
  assign cand_blk = cand_addr & ~OFF_MASK;
  assign cand_rdy = base_time + TW'(cand_delay);
  assign ntf_take = ntf_valid && !ntf_uncached && !(ntf_ifetch && cfg_data_only);

  // one operation per cycle, fixed priority
  always_comb begin
    if (ntf_valid)       op = ntf_take ? OP_NOTE : OP_IDLE;
    else if (cand_valid) op = OP_CAND;
    else if (searching)  op = OP_STEP;
    else                 op = OP_IDLE;
  end

  pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_ntf_match (
    .key(ntf_blk), .ent(q_addr), .used(count), .hit(n_hit), .idx(n_idx)
  );

  pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_cand_match (
    .key(cand_blk), .ent(q_addr), .used(count), .hit(c_hit), .idx(c_idx)
  );

  // queue with the matching entry closed up
  always_comb begin
    a_addr = q_addr;
    a_rdy  = q_rdy;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (n_hit && (IDXW'(i) >= n_idx)) begin
        a_addr[i] = q_addr[i+1];
        a_rdy[i]  = q_rdy[i+1];
      end
    end
    cnt1 = count - CNTW'(n_hit);
  end

  // queue with the head popped
  always_comb begin
    s_addr = q_addr;
    s_rdy  = q_rdy;
    for (int i = 0; i < DEPTH - 1; i++) begin
      s_addr[i] = q_addr[i+1];
      s_rdy[i]  = q_rdy[i+1];
    end
  end

  pfq_cutoff #(.TW(TW), .DEPTH(DEPTH)) u_cut (
    .rdy(a_rdy), .used(cnt1), .thresh(ntf_time), .keep(keep)
  );

  always_comb begin
    n_addr   = q_addr;
    n_rdy    = q_rdy;
    n_count  = count;
    n_base   = base_time;
    n_search = searching;
    n_done   = 1'b0;
    n_found  = 1'b0;
    n_iaddr  = issue_addr;
    for (int k = 0; k < NUM_EV; k++) ev_inc[k] = '0;
    if (!searching && issue_req) n_search = 1'b1;
    case (op)
      OP_NOTE: begin
        n_addr = a_addr;
        n_rdy  = a_rdy;
        n_base = ntf_time;
        ev_inc[EV_MISSDROP] = CNTW'(n_hit);
        if (cfg_serial_squash) begin
          n_count = keep;
          ev_inc[EV_SQUASH] = cnt1 - keep;
        end else begin
          n_count = cnt1;
        end
      end
      OP_CAND: begin
        ev_inc[EV_IDENT] = CNTW'(1);
        if (c_hit) begin
          ev_inc[EV_BUFHIT] = CNTW'(1);
        end else if (count == FULL_CNT) begin
          n_addr = s_addr;
          n_rdy  = s_rdy;
          n_addr[DEPTH-1] = cand_blk;
          n_rdy[DEPTH-1]  = cand_rdy;
          ev_inc[EV_FULLDROP] = CNTW'(1);
        end else begin
          n_addr[count[IDXW-1:0]] = cand_blk;
          n_rdy[count[IDXW-1:0]]  = cand_rdy;
          n_count = count + CNTW'(1);
        end
      end
      OP_STEP: begin
        if (count == '0) begin
          n_search = 1'b0;
          n_done   = 1'b1;
        end else begin
          n_addr  = s_addr;
          n_rdy   = s_rdy;
          n_count = count - CNTW'(1);
          if (probe_cache_hit) begin
            ev_inc[EV_CACHEHIT] = CNTW'(1);
          end else if (probe_mshr_hit) begin
            ev_inc[EV_MSHRHIT] = CNTW'(1);
          end else begin
            n_search = 1'b0;
            n_done   = 1'b1;
            n_found  = 1'b1;
            n_iaddr  = q_addr[0];
            ev_inc[EV_ISSUE] = CNTW'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      base_time   <= '0;
      searching   <= 1'b0;
      issue_done  <= 1'b0;
      issue_found <= 1'b0;
      issue_addr  <= '0;
    end else begin
      count       <= n_count;
      base_time   <= n_base;
      searching   <= n_search;
      issue_done  <= n_done;
      issue_found <= n_found;
      issue_addr  <= n_iaddr;
    end
  end

  // entry payload carries no reset; occupancy is tracked by count
  always_ff @(posedge clk) begin
    q_addr <= n_addr;
    q_rdy  <= n_rdy;
  end

  pfq_evcnt #(.NEV(NUM_EV), .CW(CW), .IW(CNTW)) u_ev (
    .clk(clk), .rst(rst), .inc(ev_inc), .cnt_flat(ev_counts)
  );

  assign probe_addr = q_addr[0];
  assign mem_req    = (count != '0);
  assign head_time  = (count != '0) ? q_rdy[0] : '0;

  // ---------------- assertions ----------------
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CAND && !c_hit && count == FULL_CNT) |=> (count == FULL_CNT));

  p_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && !ntf_take) |=> $stable(count) && $stable(base_time));

  p_squash_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOTE) |=> (count <= $past(count)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    issue_done |=> !issue_done);

  p_found_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    issue_found |-> issue_done);

  p_found_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    issue_found |-> ((issue_addr & OFF_MASK) == '0));

  p_cand_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && cand_valid && !ntf_take) |=> $stable(count));

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ndi
      for (genvar gj = gi + 1; gj < DEPTH; gj++) begin : g_ndj
        p_nodup_r6: assert property (@(posedge clk) disable iff (rst)
          (CNTW'(gj) < count) |-> (q_addr[gi] != q_addr[gj]));
      end
    end
  endgenerate
endmodule

// File: tb/prefetch_queue_ctrl_test.sv
module prefetch_queue_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_data_only, cfg_serial_squash;
  logic        ntf_valid, ntf_uncached, ntf_ifetch;
  logic [31:0] ntf_addr;
  logic [15:0] ntf_time;
  logic        cand_valid;
  logic [31:0] cand_addr;
  logic [7:0]  cand_delay;
  logic        issue_req;
  logic [31:0] probe_addr;
  logic        probe_cache_hit, probe_mshr_hit;
  logic        issue_done, issue_found;
  logic [31:0] issue_addr;
  logic        mem_req;
  logic [15:0] head_time;
  logic [8*CW-1:0] ev_counts;

  int checks = 0;
  int errors = 0;
  int exp_ev [8];
  logic [31:0] c_list [4];
  logic [31:0] m_list [4];
  int n_c = 0;
  int n_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue_ctrl uut (
    .clk(clk), .rst(rst), .cfg_data_only(cfg_data_only),
    .cfg_serial_squash(cfg_serial_squash), .ntf_valid(ntf_valid),
    .ntf_addr(ntf_addr), .ntf_time(ntf_time), .ntf_uncached(ntf_uncached),
    .ntf_ifetch(ntf_ifetch), .cand_valid(cand_valid), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .issue_req(issue_req), .probe_addr(probe_addr),
    .probe_cache_hit(probe_cache_hit), .probe_mshr_hit(probe_mshr_hit),
    .issue_done(issue_done), .issue_found(issue_found), .issue_addr(issue_addr),
    .mem_req(mem_req), .head_time(head_time), .ev_counts(ev_counts)
  );

  // lookup models
  always_comb begin
    probe_cache_hit = 1'b0;
    probe_mshr_hit  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i < n_c && c_list[i] == probe_addr) probe_cache_hit = 1'b1;
      if (i < n_m && m_list[i] == probe_addr) probe_mshr_hit = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ev(input string req);
    for (int k = 0; k < 8; k++)
      chk(req, $sformatf("counter %0d", k), ev_counts[k*CW +: CW], exp_ev[k]);
  endtask

  task automatic notify(input logic [31:0] a, input logic [15:0] t,
                        input logic unc, input logic ifetch);
    ntf_valid = 1'b1; ntf_addr = a; ntf_time = t; ntf_uncached = unc; ntf_ifetch = ifetch;
    @(negedge clk);
    ntf_valid = 1'b0; ntf_uncached = 1'b0; ntf_ifetch = 1'b0;
  endtask

  task automatic cand(input logic [31:0] a, input logic [7:0] d);
    cand_valid = 1'b1; cand_addr = a; cand_delay = d;
    @(negedge clk);
    cand_valid = 1'b0;
  endtask

  task automatic issue(input logic ef, input logic [31:0] ea, input int ecyc, input string req);
    int cyc;
    issue_req = 1'b1;
    @(negedge clk);
    issue_req = 1'b0;
    cyc = 1;
    while (!issue_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, "issue latency", cyc, ecyc);
    chk(req, "issue_found", issue_found, ef);
    if (ef) chk(req, "issue_addr", issue_addr, ea);
  endtask

  task automatic t_reset;
    chk("R11", "mem_req", mem_req, 0);
    chk("R11", "head_time", head_time, 0);
    chk("R11", "issue_done", issue_done, 0);
    chk_ev("R11");
  endtask

  task automatic t_basic;
    notify(32'h1000, 16'd100, 0, 0);
    cand(32'h2004, 8'd5); exp_ev[0]++;
    chk("R5", "head_time", head_time, 105);
    chk("R9", "mem_req busy", mem_req, 1);
    cand(32'h3000, 8'd2); exp_ev[0]++;
    chk("R5", "head_time after tail append", head_time, 105);
    issue(1, 32'h2000, 2, "R1"); exp_ev[7]++;
    chk("R5", "head_time second", head_time, 102);
    issue(1, 32'h3000, 2, "R8"); exp_ev[7]++;
    chk("R9", "mem_req drained", mem_req, 0);
    chk("R5", "head_time empty", head_time, 0);
    issue(0, 32'h0, 2, "R8");
    chk_ev("R12");
  endtask

  task automatic t_dup;
    notify(32'h5000, 16'd200, 0, 0);
    cand(32'h4000, 8'd1); exp_ev[0]++;
    cand(32'h4010, 8'd3); exp_ev[0]++; exp_ev[1]++;
    chk("R6", "head_time", head_time, 201);
    issue(1, 32'h4000, 2, "R6"); exp_ev[7]++;
    chk("R6", "mem_req after dup", mem_req, 0);
    chk_ev("R6");
  endtask

  task automatic t_remove;
    notify(32'h9000, 16'd50, 0, 0);
    cand(32'h6000, 8'd1); cand(32'h7000, 8'd2); cand(32'h8000, 8'd3);
    exp_ev[0] += 3;
    notify(32'h7020, 16'd20, 0, 0); exp_ev[5]++;
    chk("R3", "head_time", head_time, 51);
    issue(1, 32'h6000, 2, "R3"); exp_ev[7]++;
    issue(1, 32'h8000, 2, "R3"); exp_ev[7]++;
    chk("R4", "no squash when off", mem_req, 0);
    chk_ev("R3");
  endtask

  task automatic t_squash;
    cfg_serial_squash = 1'b1;
    notify(32'hF000, 16'd100, 0, 0);
    cand(32'h10000, 8'd10); cand(32'h11000, 8'd2); cand(32'h12000, 8'd20);
    exp_ev[0] += 3;
    notify(32'h13000, 16'd105, 0, 0); exp_ev[6]++;
    chk("R4", "head_time", head_time, 110);
    issue(1, 32'h10000, 2, "R4"); exp_ev[7]++;
    issue(1, 32'h11000, 2, "R4"); exp_ev[7]++;
    chk("R4", "mem_req", mem_req, 0);
    notify(32'hF000, 16'd100, 0, 0);
    cand(32'h14000, 8'd0); exp_ev[0]++;
    notify(32'h15000, 16'd100, 0, 0); exp_ev[6]++;
    chk("R4", "equal time squashed", mem_req, 0);
    chk("R9", "head_time empty", head_time, 0);
    chk_ev("R4");
    cfg_serial_squash = 1'b0;
  endtask

  task automatic t_full;
    notify(32'h0, 16'd0, 0, 0);
    for (int i = 0; i < 9; i++) begin
      cand(32'h20000 + i*32'h40, 8'(i + 1)); exp_ev[0]++;
    end
    exp_ev[4]++;
    chk("R7", "head_time after evict", head_time, 2);
    for (int i = 1; i < 9; i++) begin
      issue(1, 32'h20000 + i*32'h40, 2, "R7"); exp_ev[7]++;
    end
    chk("R7", "mem_req", mem_req, 0);
    chk_ev("R7");
  endtask

  task automatic t_skip;
    notify(32'h0, 16'd0, 0, 0);
    cand(32'h30000, 8'd1); cand(32'h31000, 8'd2); cand(32'h32000, 8'd3);
    exp_ev[0] += 3;
    c_list[0] = 32'h30000; n_c = 1;
    m_list[0] = 32'h31000; n_m = 1;
    issue(1, 32'h32000, 4, "R8"); exp_ev[2]++; exp_ev[3]++; exp_ev[7]++;
    cand(32'h33000, 8'd1); cand(32'h30000, 8'd1); exp_ev[0] += 2;
    c_list[1] = 32'h33000; n_c = 2;
    m_list[1] = 32'h30000; n_m = 2;
    issue(0, 32'h0, 4, "R8"); exp_ev[2] += 2;
    chk("R9", "mem_req after filtering", mem_req, 0);
    n_c = 0; n_m = 0;
    chk_ev("R8");
  endtask

  task automatic t_ignore;
    cfg_data_only = 1'b1;
    notify(32'h0, 16'd300, 0, 0);
    cand(32'h40000, 8'd0); exp_ev[0]++;
    notify(32'h40000, 16'd500, 1, 0);
    chk("R2", "uncached kept entry", mem_req, 1);
    chk("R2", "uncached head_time", head_time, 300);
    notify(32'h40000, 16'd600, 0, 1);
    chk("R2", "ifetch kept entry", mem_req, 1);
    cand(32'h41000, 8'd4); exp_ev[0]++;
    issue(1, 32'h40000, 2, "R2"); exp_ev[7]++;
    chk("R2", "time base unchanged", head_time, 304);
    cfg_data_only = 1'b0;
    notify(32'h41000, 16'd700, 0, 1); exp_ev[5]++;
    chk("R2", "ifetch accepted when data-only off", mem_req, 0);
    chk_ev("R2");
  endtask

  task automatic t_priority;
    ntf_valid = 1'b1; ntf_addr = 32'h50000; ntf_time = 16'd900;
    cand_valid = 1'b1; cand_addr = 32'h51000; cand_delay = 8'd1;
    @(negedge clk);
    ntf_valid = 1'b0; cand_valid = 1'b0;
    chk("R10", "candidate with notification dropped", mem_req, 0);
    cand(32'h52000, 8'd1); exp_ev[0]++;
    issue_req = 1'b1; cand_valid = 1'b1; cand_addr = 32'h53000; cand_delay = 8'd2;
    @(negedge clk);
    issue_req = 1'b0; cand_valid = 1'b0; exp_ev[0]++;
    begin
      int cyc;
      cyc = 1;
      while (!issue_done && cyc < 40) begin
        @(negedge clk);
        cyc++;
      end
      chk("R10", "issue latency with candidate", cyc, 2);
      chk("R10", "issue_addr", issue_addr, 32'h52000);
    end
    exp_ev[7]++;
    chk("R10", "head_time", head_time, 902);
    issue(1, 32'h53000, 2, "R10"); exp_ev[7]++;
    chk_ev("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_ev[k] = 0;
    rst = 1'b1;
    cfg_data_only = 1'b0; cfg_serial_squash = 1'b0;
    ntf_valid = 1'b0; ntf_addr = '0; ntf_time = '0; ntf_uncached = 1'b0; ntf_ifetch = 1'b0;
    cand_valid = 1'b0; cand_addr = '0; cand_delay = '0; issue_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_dup;
    t_remove;
    t_squash;
    t_full;
    t_skip;
    t_ignore;
    t_priority;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule